// File: doc/BRIEF.md
# Burst Address Sequencer

This block supplies the access address for a memory that serves bursts of up to four consecutive words. When a burst begins, it captures the full external address. After that, on each cycle with the advance input asserted, it produces the next address in the burst without a new external address. Only the two lowest address bits move inside a burst. The upper bits keep the value captured at the start.

A static order select picks how the two low bits step. In linear order the low bits count up from the starting value and wrap modulo four. In interleaved order the low bits are the starting value XORed with the count of advances taken so far.

A burst can be opened by either of two active-low start strobes. The processor-side strobe needs only the first chip enable. The cache-side strobe needs the device to be fully selected. A qualified start always wins over advance in the same cycle. The address and counter registers are clocked, so the output shows each load or step one clock after the edge that samples it.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the burst state clears, and from the next cycle `addr_out` reads 0.
- R2: If `start_proc_n` is 0 and `cs1_n` is 0 at an edge, the burst restarts: from the next cycle `addr_out` equals the `addr_in` value sampled at that edge. The levels of `cs2` and `cs3_n` have no effect on this start.
- R3: If `start_cache_n` is 0 at an edge while the device is selected (`cs1_n`=0, `cs2`=1, `cs3_n`=0), the burst restarts in the same way as in R2.
- R4: `start_proc_n` low while `cs1_n` is 1 does not start a burst. With `adv_n` high, `addr_out` stays unchanged.
- R5: `start_cache_n` low while any of the three select conditions fails does not start a burst. With `adv_n` high, `addr_out` stays unchanged.
- R6: With `order_il`=0 (linear), after n advances the low two bits of `addr_out` are (s + n) mod 4, where s is the starting low two bits.
- R7: With `order_il`=1 (interleaved), after n advances the low two bits of `addr_out` are s XOR (n mod 4).
- R8: A cycle with no qualified start and `adv_n`=1 leaves `addr_out` unchanged.
- R9: Between starts, bits above bit 1 of `addr_out` keep the value loaded at the start. After four advances the low bits return to the start value.
- R10: A qualified start together with `adv_n`=0 loads `addr_in` and takes no step.
- R11: When both strobes qualify in the same cycle, the result is one ordinary load of `addr_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | ADDR_W | External address captured when a burst starts |
| start_proc_n | input | 1 | Processor-side burst start, active low |
| start_cache_n | input | 1 | Cache-side burst start, active low |
| adv_n | input | 1 | Advance to the next burst address, active low |
| order_il | input | 1 | Burst order select: 0 linear, 1 interleaved |
| cs1_n | input | 1 | First chip enable, active low |
| cs2 | input | 1 | Second chip enable, active high |
| cs3_n | input | 1 | Third chip enable, active low |
| addr_out | output | ADDR_W | Current access address |

## Verification
The bench builds the block with `ADDR_W`=6, so the address space is only 64 words. This lets it start a burst at every address, in both orders, using both strobes in turn. Each burst is advanced past the four-step wrap. This reaches every combination of starting low bits and count, and it shows the upper four bits held through each burst. Separate sequences cover each deselect condition on both strobes, a start that collides with advance, and two starts arriving together.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    // Width of the in-burst counter: four beats per burst.
    localparam int BURST_W = 2;

    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } burst_order_e;

    // Result of start-strobe qualification.
    typedef struct packed {
        logic load;      // some strobe qualified this cycle
        logic by_proc;   // processor-side strobe qualified
        logic by_cache;  // cache-side strobe qualified
    } start_t;

    // Low address bits for a given beat of the burst.
    function automatic logic [BURST_W-1:0] beat_low(
        input logic [BURST_W-1:0] first,
        input logic [BURST_W-1:0] beat,
        input burst_order_e       order
    );
        logic [BURST_W-1:0] r;
        if (order == ORDER_INTERLEAVE) r = first ^ beat;
        else                           r = first + beat;
        return r;
    endfunction

endpackage

// File: rtl/burst_start_qual.sv
module burst_start_qual
    import burst_seq_pkg::*;
(
    input  logic   start_proc_n,
    input  logic   start_cache_n,
    input  logic   cs1_n,
    input  logic   cs2,
    input  logic   cs3_n,
    output start_t start
);
    logic selected;

    always_comb begin
        selected       = !cs1_n && cs2 && !cs3_n;
        start.by_proc  = !start_proc_n && !cs1_n;
        start.by_cache = !start_cache_n && selected;
        start.load     = start.by_proc || start.by_cache;
    end

endmodule

// File: rtl/burst_state.sv
module burst_state #(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] base_q,
    output logic [CNT_W-1:0]  beat_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            beat_q <= '0;
        end else if (load) begin
            base_q <= addr_in;
            beat_q <= '0;
        end else if (step) begin
            beat_q <= beat_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = BURST_W
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  beat,
    input  burst_order_e      order,
    output logic [ADDR_W-1:0] addr
);
    logic [CNT_W-1:0] low;

    assign low = beat_low(base[CNT_W-1:0], beat, order);

    generate
        if (ADDR_W > CNT_W) begin : g_with_upper
            assign addr = {base[ADDR_W-1:CNT_W], low};
        end else begin : g_low_only
            assign addr = low;
        end
    endgenerate

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              start_proc_n,
    input  logic              start_cache_n,
    input  logic              adv_n,
    input  logic              order_il,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              cs3_n,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int CNT_W = BURST_W;

    start_t             start;
    logic [ADDR_W-1:0]  base_q;
    logic [CNT_W-1:0]   beat_q;
    burst_order_e       order;

    assign order = burst_order_e'(order_il);

    burst_start_qual u_qual (
        .start_proc_n  (start_proc_n),
        .start_cache_n (start_cache_n),
        .cs1_n         (cs1_n),
        .cs2           (cs2),
        .cs3_n         (cs3_n),
        .start         (start)
    );

    // A qualified start takes priority over advance inside burst_state.
    burst_state #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_state (
        .clk     (clk),
        .rst     (rst),
        .load    (start.load),
        .step    (!adv_n),
        .addr_in (addr_in),
        .base_q  (base_q),
        .beat_q  (beat_q)
    );

    burst_addr_map #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_map (
        .base  (base_q),
        .beat  (beat_q),
        .order (order),
        .addr  (addr_out)
    );

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr_in,
    input logic              start_proc_n,
    input logic              start_cache_n,
    input logic              adv_n,
    input logic              order_il,
    input logic              cs1_n,
    input logic              cs2,
    input logic              cs3_n,
    input logic [ADDR_W-1:0] addr_out
);
    localparam int CNT_W = burst_seq_pkg::BURST_W;

    logic             past_valid;
    logic             rst_q;
    logic             load_ev;
    logic [CNT_W-1:0] low_now;
    logic [CNT_W-1:0] low_q;
    logic [CNT_W-1:0] low_inc;

    // Start qualification written from the port-level rule.
    assign load_ev = (!start_proc_n && !cs1_n) ||
                     (!start_cache_n && !cs1_n && cs2 && !cs3_n);
    assign low_now = addr_out[CNT_W-1:0];
    assign low_inc = low_q + CNT_W'(1);

    always_ff @(posedge clk) begin
        rst_q      <= rst;
        past_valid <= !rst;
        low_q      <= low_now;
    end

    // R1
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
        (rst_q === 1'b1) |-> (addr_out == '0));

    // R2, R3, R10, R11
    a_r2_start_loads: assert property (@(posedge clk) disable iff (rst)
        (past_valid && $past(load_ev)) |-> (addr_out == $past(addr_in)));

    // R8, R4, R5
    a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (past_valid && $past(!load_ev && adv_n) && $stable(order_il))
            |-> $stable(addr_out));

    // R9
    a_r9_upper_fixed: assert property (@(posedge clk) disable iff (rst)
        (past_valid && $past(!load_ev))
            |-> (addr_out[ADDR_W-1:CNT_W] == $past(addr_out[ADDR_W-1:CNT_W])));

    // R6
    a_r6_linear_step: assert property (@(posedge clk) disable iff (rst)
        (past_valid && $past(!load_ev && !adv_n) && !order_il && $stable(order_il))
            |-> (low_now == low_inc));

    // R7: each interleaved step flips the lowest bit
    a_r7_step_flips_lsb: assert property (@(posedge clk) disable iff (rst)
        (past_valid && $past(!load_ev && !adv_n) && order_il && $stable(order_il))
            |-> (low_now[0] != low_q[0]));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .addr_in       (addr_in),
    .start_proc_n  (start_proc_n),
    .start_cache_n (start_cache_n),
    .adv_n         (adv_n),
    .order_il      (order_il),
    .cs1_n         (cs1_n),
    .cs2           (cs2),
    .cs3_n         (cs3_n),
    .addr_out      (addr_out)
);

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr_in;
    logic          start_proc_n, start_cache_n, adv_n, order_il;
    logic          cs1_n, cs2, cs3_n;
    logic [AW-1:0] addr_out;

    int checks   = 0;
    int failures = 0;

    always #10 clk = ~clk;   // 50 MHz

    burst_addr_seq #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .addr_in(addr_in),
        .start_proc_n(start_proc_n), .start_cache_n(start_cache_n),
        .adv_n(adv_n), .order_il(order_il),
        .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .addr_out(addr_out)
    );

    function automatic logic [AW-1:0] model(input logic [AW-1:0] b,
                                            input int n, input logic il);
        logic [1:0] s;
        logic [1:0] k;
        s = b[1:0];
        k = 2'(n % 4);
        return {b[AW-1:2], il ? (s ^ k) : 2'(s + k)};
    endfunction

    task automatic check(input string tag, input logic [AW-1:0] exp);
        checks++;
        if (addr_out !== exp) begin
            failures++;
            $display("FAIL %s: addr_out=%0h expected=%0h", tag, addr_out, exp);
        end
    endtask

    // Drive one cycle at a falling edge; outputs are sampled at the next one.
    task automatic cyc(input logic pn, input logic cn, input logic an,
                       input logic c1n, input logic c2, input logic c3n,
                       input logic [AW-1:0] a);
        start_proc_n  = pn;
        start_cache_n = cn;
        adv_n         = an;
        cs1_n         = c1n;
        cs2           = c2;
        cs3_n         = c3n;
        addr_in       = a;
        @(negedge clk);
    endtask

    task automatic idle(input logic [AW-1:0] a);
        cyc(1, 1, 1, 0, 1, 0, a);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [AW-1:0] cur;
        rst = 1'b1;
        order_il = 1'b1;
        start_proc_n = 1; start_cache_n = 1; adv_n = 1;
        cs1_n = 0; cs2 = 1; cs3_n = 0; addr_in = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle('0);
        check("R1 reset value", '0);

        // Full sweep: every start address, both orders, alternating strobes.
        for (int m = 0; m < 2; m++) begin
            order_il = 1'(m);
            for (int a = 0; a < (1 << AW); a++) begin
                if (a % 2 == 0) begin
                    cyc(0, 1, 1, 0, a % 3 == 0, 1, AW'(a));   // R2: cs2/cs3_n irrelevant
                    check("R2 proc start load", AW'(a));
                end else begin
                    cyc(1, 0, 1, 0, 1, 0, AW'(a));
                    check("R3 cache start load", AW'(a));
                end
                for (int n = 1; n <= 5; n++) begin
                    cyc(1, 1, 0, 0, 1, 0, ~AW'(a));
                    if (m == 0) check("R6 linear beat", model(AW'(a), n, 0));
                    else        check("R7 interleave beat", model(AW'(a), n, 1));
                    if (n == 4) check("R9 wrap to start", AW'(a));
                    if (n == 2) begin
                        idle(~AW'(a));
                        check("R8 hold without advance", model(AW'(a), 2, 1'(m)));
                    end
                end
            end
        end

        // Deselected strobes (linear order, burst at 0x15 advanced once).
        order_il = 1'b0;
        cyc(0, 1, 1, 0, 1, 0, 6'h15);
        cyc(1, 1, 0, 0, 1, 0, 6'h00);
        cur = model(6'h15, 1, 0);
        check("R6 setup step", cur);
        cyc(0, 1, 1, 1, 1, 0, 6'h2a);
        check("R4 proc ignored cs1_n high", cur);
        cyc(1, 0, 1, 1, 1, 0, 6'h2a);
        check("R5 cache ignored cs1_n high", cur);
        cyc(1, 0, 1, 0, 0, 0, 6'h2a);
        check("R5 cache ignored cs2 low", cur);
        cyc(1, 0, 1, 0, 1, 1, 6'h2a);
        check("R5 cache ignored cs3_n high", cur);
        cyc(1, 1, 0, 0, 1, 0, 6'h2a);
        check("R9 burst continues after ignored strobes", model(6'h15, 2, 0));

        // Start collides with advance.
        cyc(0, 1, 0, 0, 1, 0, 6'h3e);
        check("R10 start beats advance (proc)", 6'h3e);
        cyc(1, 0, 0, 0, 1, 0, 6'h0b);
        check("R10 start beats advance (cache)", 6'h0b);
        order_il = 1'b1;
        cyc(1, 1, 0, 0, 1, 0, 6'h00);
        check("R7 first step after restart", model(6'h0b, 1, 1));

        // Both strobes at once.
        cyc(0, 0, 1, 0, 1, 0, 6'h27);
        check("R11 both strobes load", 6'h27);
        cyc(1, 1, 0, 0, 1, 0, 6'h00);
        check("R11 single burst after dual start", model(6'h27, 1, 1));

        // Reset mid-burst.
        rst = 1'b1;
        idle(6'h11);
        rst = 1'b0;
        idle(6'h11);
        check("R1 reset clears burst", '0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule